// File: doc/BRIEF.md
# Flash Program/Erase Pulse Timer

This block produces the timing window for one flash operation: programming a word, erasing one page, or erasing the whole array. A start request with a 2-bit operation code launches a fixed sequence. First comes a settling delay. Then a high-voltage pulse window follows, whose width depends on the operation. A second settling delay comes after the pulse, and a one-cycle completion strobe ends the sequence. Every duration is counted in enables from an external prescaler, so the system clock rate does not change the timing.

Four byte-wide reload registers set the durations. Software reads and writes them over a simple register port. While an operation runs, the registers are locked so that the sequence cannot be retimed part-way through. The flash array, the prescaler itself, address and data capture, and charge-pump control all sit outside this block.

Top module: `flash_pulse_timer`

## Requirements
- R1: After reset the registers read 0x30 (settle, address 0), 0x16 (program width, address 1), 0x04 (page-erase width, address 2) and 0xEA (array-erase width, address 3); busy, hvActive and doneStrobe are low.
- R2: While busy is low, a write (regWr high for one clock) stores regWrData at regAddr. regRdData shows the register at regAddr combinationally.
- R3: A write is ignored while busy is high. It is also ignored in the clock where a start request is accepted.
- R4: A start request is accepted only when busy is low and startOp is 0 (program), 1 (page erase) or 2 (array erase), and busy is high from the next clock. Code 3 is ignored.
- R5: The leading settle phase (busy high, hvActive low) lasts SETTLE+1 prescaler enables, where SETTLE is the value at address 0.
- R6: For a program operation, hvActive is high for 8 × (V+1) prescaler enables, where V is the value at address 1.
- R7: For a page erase, hvActive is high for 4096 × (V+1) prescaler enables, where V is the value at address 2.
- R8: For an array erase, hvActive is high for 4096 × (V+1) prescaler enables, where V is the value at address 3.
- R9: The trailing settle phase (busy high, hvActive low, after the pulse) lasts SETTLE+1 prescaler enables.
- R10: doneStrobe is high for exactly one clock, in the clock after the last trailing enable, with busy still high. busy is low in the following clock.
- R11: Phase counting advances only in clocks where tickEn is high, whatever the spacing of the enables.
- R12: A start request while busy is ignored. The operation code captured at acceptance sets the pulse width for the whole operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Prescaler output enable, one clock wide |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr |
| startReq | input | 1 | Operation start request |
| startOp | input | 2 | Operation code: 0 program, 1 page erase, 2 array erase |
| busy | output | 1 | Operation in progress |
| hvActive | output | 1 | High-voltage pulse window |
| doneStrobe | output | 1 | One-clock completion strobe |

## Verification
The in-line properties check on every clock that the register lock holds, that the operation code stays fixed once captured, and that the phase counter never decrements past zero. They also check that busy rises only after a request, that the phase stalls in any clock without an enable, and that completion follows the last trailing enable and clears busy one clock later. Only the bench's scenarios can show the phase lengths themselves. The bench counts enables per phase against the multipliers, under several enable spacings, register values and operation codes. It also shows that writes and conflicting starts made mid-operation leave no trace in the readback or in the pulse width.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  localparam int NUM_REGS = 4;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_PAGE = 2'd1,
    OP_MASS = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SRC_SETTLE = 2'd0,
    SRC_PROG   = 2'd1,
    SRC_PAGE   = 2'd2,
    SRC_MASS   = 2'd3
  } src_e;

  // strobes from the sequencer to the counter datapath
  typedef struct packed {
    logic load;
    src_e src;
    logic dec;
  } ctl_s;
endpackage

// File: rtl/fpt_regs.sv
module fpt_regs
  import fpt_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] RST_SETTLE = 8'h30,
  parameter logic [DW-1:0] RST_PROG   = 8'h16,
  parameter logic [DW-1:0] RST_PAGE   = 8'h04,
  parameter logic [DW-1:0] RST_MASS   = 8'hEA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wrData,
  input  logic              lock,
  output logic [DW-1:0]     rdData,
  output logic [DW-1:0]     settleVal,
  output logic [DW-1:0]     progVal,
  output logic [DW-1:0]     pageVal,
  output logic [DW-1:0]     massVal
);
  localparam logic [DW-1:0] RST_VALS [NUM_REGS] = '{RST_SETTLE, RST_PROG, RST_PAGE, RST_MASS};

  logic [DW-1:0] regQ [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regQ[i] <= RST_VALS[i];
      end else if (wrEn && !lock && (addr == ADDR_W'(i))) begin
        regQ[i] <= wrData;
      end
    end

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      lock |=> $stable(regQ[i]));
  end

  assign rdData    = regQ[addr];
  assign settleVal = regQ[0];
  assign progVal   = regQ[1];
  assign pageVal   = regQ[2];
  assign massVal   = regQ[3];
endmodule

// File: rtl/fpt_datapath.sv
module fpt_datapath
  import fpt_pkg::*;
#(
  parameter int DW = 8,
  parameter int CNT_W = 21,
  parameter int PROG_SHIFT = 3,
  parameter int ERASE_SHIFT = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctl_s          ctl,
  input  logic [DW-1:0] settleVal,
  input  logic [DW-1:0] progVal,
  input  logic [DW-1:0] pageVal,
  input  logic [DW-1:0] massVal,
  output logic          cntZero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  // phase of N enables is held as N-1 so that zero marks the last enable
  function automatic logic [CNT_W-1:0] scaled(input logic [DW-1:0] v, input int sh);
    return ((CNT_W'(v) + ONE) << sh) - ONE;
  endfunction

  always_comb begin
    unique case (ctl.src)
      SRC_SETTLE: loadVal = CNT_W'(settleVal);
      SRC_PROG:   loadVal = scaled(progVal, PROG_SHIFT);
      SRC_PAGE:   loadVal = scaled(pageVal, ERASE_SHIFT);
      default:    loadVal = scaled(massVal, ERASE_SHIFT);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.load) begin
      cnt <= loadVal;
    end else if (ctl.dec) begin
      cnt <= cnt - ONE;
    end
  end

  assign cntZero = (cnt == '0);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dec |-> (cnt != '0));
endmodule

// File: rtl/fpt_ctrl.sv
module fpt_ctrl
  import fpt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       startReq,
  input  logic [1:0] startOp,
  input  logic       cntZero,
  output ctl_s       ctl,
  output logic       accept,
  output logic       busy,
  output logic       hvActive,
  output logic       doneStrobe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_PULSE, ST_TRAIL, ST_DONE
  } state_e;

  state_e state, stateNext;
  op_e    curOp;
  op_e    reqOp;
  src_e   pulseSrc;

  assign reqOp = op_e'(startOp);

  always_comb begin
    unique case (curOp)
      OP_PAGE: pulseSrc = SRC_PAGE;
      OP_MASS: pulseSrc = SRC_MASS;
      default: pulseSrc = SRC_PROG;
    endcase
  end

  always_comb begin
    stateNext = state;
    accept    = 1'b0;
    ctl       = '{load: 1'b0, src: SRC_SETTLE, dec: 1'b0};
    unique case (state)
      ST_IDLE: begin
        if (startReq && reqOp != OP_NONE) begin
          accept    = 1'b1;
          ctl.load  = 1'b1;
          stateNext = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (tickEn) begin
          if (cntZero) begin
            ctl.load  = 1'b1;
            ctl.src   = pulseSrc;
            stateNext = ST_PULSE;
          end else begin
            ctl.dec = 1'b1;
          end
        end
      end
      ST_PULSE: begin
        if (tickEn) begin
          if (cntZero) begin
            ctl.load  = 1'b1;
            stateNext = ST_TRAIL;
          end else begin
            ctl.dec = 1'b1;
          end
        end
      end
      ST_TRAIL: begin
        if (tickEn) begin
          if (cntZero) stateNext = ST_DONE;
          else         ctl.dec = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curOp <= OP_PROG;
    end else begin
      state <= stateNext;
      if (accept) curOp <= reqOp;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign hvActive   = (state == ST_PULSE);
  assign doneStrobe = (state == ST_DONE);

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

  // R12
  op_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !doneStrobe) |=> $stable(curOp));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> (!doneStrobe && !busy));

  // R9
  done_after_trail_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> $past(state == ST_TRAIL && tickEn && cntZero));

  // R11
  stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && (state == ST_LEAD || state == ST_PULSE || state == ST_TRAIL)) |=> $stable(state));
endmodule

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer
  import fpt_pkg::*;
#(
  parameter int DW = 8,
  parameter int CNT_W = 21,
  parameter int PROG_SHIFT = 3,
  parameter int ERASE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     regRdData,
  input  logic              startReq,
  input  logic [1:0]        startOp,
  output logic              busy,
  output logic              hvActive,
  output logic              doneStrobe
);
  ctl_s          ctl;
  logic          accept;
  logic          cntZero;
  logic [DW-1:0] settleVal, progVal, pageVal, massVal;

  fpt_regs #(.DW(DW)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(regWr), .addr(regAddr), .wrData(regWrData),
    .lock(busy | accept), .rdData(regRdData), .settleVal(settleVal),
    .progVal(progVal), .pageVal(pageVal), .massVal(massVal)
  );

  fpt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .startReq(startReq),
    .startOp(startOp), .cntZero(cntZero), .ctl(ctl), .accept(accept),
    .busy(busy), .hvActive(hvActive), .doneStrobe(doneStrobe)
  );

  fpt_datapath #(
    .DW(DW), .CNT_W(CNT_W), .PROG_SHIFT(PROG_SHIFT), .ERASE_SHIFT(ERASE_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .settleVal(settleVal), .progVal(progVal),
    .pageVal(pageVal), .massVal(massVal), .cntZero(cntZero)
  );
endmodule

// File: tb/flash_pulse_timer_test.sv
`timescale 1ns/1ps
module flash_pulse_timer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       regWr = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       startReq = 1'b0;
  logic [1:0] startOp = 2'd0;
  logic       busy, hvActive, doneStrobe;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int tickPeriod = 1;
  int tickCnt = 0;

  int leadT, pulseT, trailT, doneCnt;
  bit firstBusy, idleAfterDone;

  // op, settle, width value, enable spacing, expected pulse enables
  localparam int NV = 6;
  localparam int V_OP    [NV] = '{0, 0, 0, 1, 2, 1};
  localparam int V_SET   [NV] = '{0, 3, 255, 2, 1, 0};
  localparam int V_VAL   [NV] = '{0, 22, 255, 0, 0, 2};
  localparam int V_PER   [NV] = '{1, 3, 1, 1, 2, 1};
  localparam int V_PULSE [NV] = '{8, 184, 2048, 4096, 4096, 12288};

  flash_pulse_timer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .startReq(startReq),
    .startOp(startOp), .busy(busy), .hvActive(hvActive), .doneStrobe(doneStrobe)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    #2;
    tickCnt++;
    tickEn = ((tickCnt % tickPeriod) == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic writeReg(input int a, input int d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 2'(a); regWrData = 8'(d);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input int a, output int d);
    @(negedge clk);
    regAddr = 2'(a);
    #1;
    d = int'(regRdData);
  endtask

  // launches an operation and counts enables seen in each phase
  task automatic runOp(input int op, input int injectAt, input bit writeWithStart);
    int idx = 0;
    bit seenPulse = 0;
    bit prevDone = 0;
    leadT = 0; pulseT = 0; trailT = 0; doneCnt = 0; idleAfterDone = 0;
    @(negedge clk);
    startReq = 1'b1; startOp = 2'(op);
    if (writeWithStart) begin
      regWr = 1'b1; regAddr = 2'd1; regWrData = 8'h5A;
    end
    while (idx < 400000) begin
      @(negedge clk);
      startReq = 1'b0; regWr = 1'b0;
      if (idx == 0) firstBusy = busy;
      if (doneStrobe) begin
        doneCnt++;
      end else if (hvActive) begin
        seenPulse = 1;
        if (tickEn) pulseT++;
      end else if (busy) begin
        if (tickEn) begin
          if (seenPulse) trailT++;
          else leadT++;
        end
      end else begin
        idleAfterDone = prevDone;
        break;
      end
      prevDone = doneStrobe;
      if (idx == injectAt) begin
        startReq = 1'b1; startOp = 2'd2;
        regWr = 1'b1; regAddr = 2'd1; regWrData = 8'h77;
      end
      idx++;
    end
  endtask

  initial begin
    int rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 hvActive", int'(hvActive), 0);
    chk("R1 doneStrobe", int'(doneStrobe), 0);
    readReg(0, rd); chk("R1 settle reset", rd, 'h30);
    readReg(1, rd); chk("R1 prog reset", rd, 'h16);
    readReg(2, rd); chk("R1 page reset", rd, 'h04);
    readReg(3, rd); chk("R1 mass reset", rd, 'hEA);

    // R2 idle write and readback
    for (int a = 0; a < 4; a++) begin
      writeReg(a, 8'hA0 + a);
      readReg(a, rd);
      chk("R2 readback", rd, 'hA0 + a);
    end

    // vector table: R5 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < NV; v++) begin
      tickPeriod = V_PER[v];
      writeReg(0, V_SET[v]);
      writeReg(V_OP[v] + 1, V_VAL[v]);
      runOp(V_OP[v], -1, 0);
      chk("R4 busy after accept", int'(firstBusy), 1);
      chk("R5 lead enables", leadT, V_SET[v] + 1);
      if (V_OP[v] == 0)      chk("R6 program pulse enables", pulseT, V_PULSE[v]);
      else if (V_OP[v] == 1) chk("R7 page pulse enables", pulseT, V_PULSE[v]);
      else                   chk("R8 array pulse enables", pulseT, V_PULSE[v]);
      chk("R9 trail enables", trailT, V_SET[v] + 1);
      chk("R10 done count", doneCnt, 1);
      chk("R10 idle after done", int'(idleAfterDone), 1);
      if (tickPeriod > 1) chk("R11 spaced enables pulse", pulseT, V_PULSE[v]);
    end

    // R4 code 3 ignored
    tickPeriod = 1;
    @(negedge clk);
    startReq = 1'b1; startOp = 2'd3;
    @(negedge clk);
    startReq = 1'b0;
    chk("R4 code 3 busy", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R4 code 3 still idle", int'(busy), 0);

    // R12 and R3: start request and write during busy
    writeReg(0, 2);
    writeReg(1, 8'h16);
    runOp(0, 5, 0);
    chk("R12 pulse keeps program width", pulseT, 184);
    chk("R12 single done", doneCnt, 1);
    readReg(1, rd);
    chk("R3 write while busy ignored", rd, 'h16);
    chk("R12 busy cleared", int'(busy), 0);

    // R3 write in the accept clock
    runOp(0, -1, 1);
    chk("R3 accept-cycle pulse", pulseT, 184);
    readReg(1, rd);
    chk("R3 write at accept ignored", rd, 'h16);

    // R2 write takes effect once idle again
    writeReg(1, 8'h03);
    readReg(1, rd);
    chk("R2 write after op", rd, 'h03);

    finishRun();
  end

  initial begin
    wait (cycles >= 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=<200000", cycles);
    finishRun();
  end
endmodule